// File: doc/BRIEF.md
# Reset Cause and Soft Reset Register

This block holds one 32-bit register that tells software why the system last came out of reset, and lets software ask for a new one. Five flag bits sit at the top of the word. The lowest flag records a button-driven external-initiated reset, the next a button-driven power-on reset, then a software external-initiated reset, then a software power-on reset. The topmost flag records a true power-on reset. All lower bits read as zero.

The two button flags and the power-on flag are cleared when software writes 1 to them. The two software flags are set when software writes 1 to them. Setting either software flag also raises a one-cycle system reset request. The block tells the first system reset after power-up apart from later ones by keeping a small saturating count of system resets. A software power-on request clears that count. A system reset with the count at zero reloads the register with the power-on value only. Any later system reset leaves the register as it was.

The register answers only at word offset BASE_ADDR+4. Offset BASE_ADDR reads as zero and ignores writes, and so does every other address. Reads are combinational from the address. Writes take effect at the clock edge where `wrEn` is high.

Top module: `rstCauseReg`

## Requirements
- R1: While `rstN` is low and right after it is released, the register reads 0 and `resetReq` is low.
- R2: A cycle with `sysRst` high while the reset count is zero loads the register with exactly 0x80000000 and increments the count. The count is zero after `rstN`.
- R3: A cycle with `sysRst` high while the reset count is non-zero leaves the register unchanged. The count saturates at its maximum and never wraps back to zero.
- R4: Write data is masked with 0xF8000000 before use, and bits 26:0 of `rdData` always read 0.
- R5: Writing 1 to bit 31, bit 28 or bit 27 clears that bit. Writing 0 to it leaves it unchanged.
- R6: Writing 1 to bit 30 or bit 29 sets that bit. Writing 0 never clears it.
- R7: Only address BASE_ADDR+4 (address bit 2 set, BASE_ADDR 8-byte aligned) is decoded. BASE_ADDR and all other addresses read 0, and writes to them change nothing and raise no request.
- R8: A write with bit 30 set clears the reset count and makes `resetReq` high for exactly the one cycle after the write edge. The next `sysRst` therefore reloads 0x80000000.
- R9: A write with bit 29 set and bit 30 clear makes `resetReq` high for one cycle but leaves the count unchanged.
- R10: A high `btnPor` sets bit 28 and a high `btnXir` sets bit 27 at the next edge. A set wins over a write-1-to-clear of the same bit in the same cycle.
- R11: In a cycle with `sysRst` high, register writes and button inputs are ignored and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset; clears the register and the count |
| sysRst | input | 1 | One cycle high for each system reset the block should observe |
| btnPor | input | 1 | Button power-on reset indication |
| btnXir | input | 1 | Button external-initiated reset indication |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Register contents change at the clock edge that samples a write, button or `sysRst`. The bench drives every stimulus on a falling edge and reads `rdData` on the next falling edge, one half period after the update. `resetReq` comes from a register, so it is checked high on the falling edge right after the write edge and low one cycle later. That confirms the pulse lasts one cycle. The count is never read directly. Its value shows up in what the next `sysRst` does to the register, checked on the falling edge after that reset, for all 1024 pairs of starting state and written flag value.

// File: rtl/rcsrPkg.sv
package rcsrPkg;
  localparam int FIELD_W   = 5;
  localparam int FIELD_LSB = 27;

  // field index 4..0 maps to register bits 31..27
  localparam int IDX_POWER   = 4;
  localparam int IDX_SFT_POR = 3;
  localparam int IDX_SFT_XIR = 2;
  localparam int IDX_BTN_POR = 1;
  localparam int IDX_BTN_XIR = 0;

  localparam logic [FIELD_W-1:0] CLR_ON_ONE = 5'b10011;
  localparam logic [FIELD_W-1:0] SET_ON_ONE = 5'b01100;
  localparam logic [FIELD_W-1:0] POWER_VAL  = 5'b10000;

  typedef struct packed {
    logic               loadPower;
    logic               readSel;
    logic [FIELD_W-1:0] clrBits;
    logic [FIELD_W-1:0] setBits;
  } strobeT;
endpackage

// File: rtl/rcsrCtrl.sv
module rcsrCtrl
  import rcsrPkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int                CNT_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sysRst,
  input  logic               btnPor,
  input  logic               btnXir,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic [FIELD_W-1:0] wrKey,
  output strobeT             strobe,
  output logic               resetReq,
  output logic               cntZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             wordHit;
  logic             wrHit;
  logic             softPor;
  logic             softXir;
  logic [CNT_W-1:0] rstCnt;
  logic [1:0]       unusedAddr;

  assign unusedAddr = regAddr[1:0];
  assign wordHit = (regAddr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]) && regAddr[2];
  assign wrHit   = wrEn && wordHit && !sysRst;
  assign softPor = wrHit && wrKey[IDX_SFT_POR];
  assign softXir = wrHit && wrKey[IDX_SFT_XIR] && !wrKey[IDX_SFT_POR];
  assign cntZero = (rstCnt == '0);

  always_comb begin
    strobe           = '0;
    strobe.readSel   = wordHit;
    strobe.loadPower = sysRst && cntZero;
    if (wrHit) begin
      strobe.clrBits = wrKey & CLR_ON_ONE;
      strobe.setBits = wrKey & SET_ON_ONE;
    end
    if (!sysRst) begin
      strobe.setBits[IDX_BTN_POR] = btnPor;
      strobe.setBits[IDX_BTN_XIR] = btnXir;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt   <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= softPor || softXir;
      if (sysRst) begin
        if (rstCnt != CNT_MAX) rstCnt <= rstCnt + 1'b1;
      end else if (softPor) begin
        rstCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rcsrData.sv
module rcsrData
  import rcsrPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  output logic [FIELD_W-1:0] regField,
  output logic [31:0]        rdData
);
  logic [FIELD_W-1:0] nextField;

  for (genvar i = 0; i < FIELD_W; i++) begin : gBit
    always_comb begin
      if (strobe.loadPower)        nextField[i] = POWER_VAL[i];
      else if (strobe.setBits[i])  nextField[i] = 1'b1;
      else if (strobe.clrBits[i])  nextField[i] = 1'b0;
      else                         nextField[i] = regField[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regField <= '0;
    else       regField <= nextField;
  end

  assign rdData = strobe.readSel ? {regField, {FIELD_LSB{1'b0}}} : 32'h0;
endmodule

// File: rtl/rstCauseReg.sv
module rstCauseReg
  import rcsrPkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int                CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysRst,
  input  logic              btnPor,
  input  logic              btnXir,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              resetReq
);
  strobeT             strobe;
  logic [FIELD_W-1:0] regField;
  logic               cntZero;
  logic               unusedLow;

  assign unusedLow = ^wrData[FIELD_LSB-1:0];

  rcsrCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .btnPor(btnPor), .btnXir(btnXir),
    .regAddr(regAddr), .wrEn(wrEn), .wrKey(wrData[31:FIELD_LSB]),
    .strobe(strobe), .resetReq(resetReq), .cntZero(cntZero)
  );

  rcsrData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regField(regField), .rdData(rdData)
  );
endmodule

// File: rtl/rstCauseRegChk.sv
module rstCauseRegChk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysRst,
  input logic              btnPor,
  input logic              btnXir,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              resetReq,
  input logic [4:0]        regField,
  input logic              cntZero
);
  logic primed;
  logic oddHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign oddHit = (regAddr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]) && regAddr[2];

  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    primed && resetReq |-> $past(wrEn && oddHit && !sysRst && (wrData[30] || wrData[29]))); // R8
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(sysRst && cntZero) |-> regField == 5'b10000); // R2
  AST_LATER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(sysRst && !cntZero) |-> regField == $past(regField)); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[26:0] == 27'h0); // R4
  AST_EVEN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr[2] |-> rdData == 32'h0); // R7
  AST_SOFT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(regField[3] && !(sysRst && cntZero)) |-> regField[3]); // R6
  AST_BTN_SET: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(btnPor && !sysRst) |-> regField[1]); // R10
endmodule

bind rstCauseReg rstCauseRegChk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .sysRst(sysRst), .btnPor(btnPor), .btnXir(btnXir),
  .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .resetReq(resetReq), .regField(regField), .cntZero(cntZero)
);

// File: tb/rstCauseReg_test.sv
`timescale 1ns/1ps
module rstCauseReg_test;
  localparam logic [15:0] BASE = 16'hF020;
  localparam logic [15:0] ODD  = 16'hF024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysRst = 1'b0, btnPor = 1'b0, btnXir = 1'b0, wrEn = 1'b0;
  logic [15:0] regAddr = ODD;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        resetReq;
  int checks = 0, failures = 0;
  logic reqSeen, reqAfter;

  always #10 clk = ~clk;

  rstCauseReg #(.ADDR_W(16), .BASE_ADDR(BASE), .CNT_W(2)) uut (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .btnPor(btnPor), .btnXir(btnXir),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .resetReq(resetReq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic pulseSys();
    @(negedge clk); sysRst = 1'b1;
    @(negedge clk); sysRst = 1'b0;
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; regAddr = ODD; reqSeen = resetReq;
    @(negedge clk); reqAfter = resetReq;
  endtask

  task automatic pulseBtn(input logic p, input logic x);
    @(negedge clk); btnPor = p; btnXir = x;
    @(negedge clk); btnPor = 1'b0; btnXir = 1'b0;
  endtask

  function automatic logic [31:0] fld(input logic [4:0] f);
    return {f, 27'h0};
  endfunction

  initial begin : watchdog
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [4:0] st, expAfter;
    logic       zeroCnt;
    #1;
    check("R1 rdData in reset", rdData, 32'h0);
    check("R1 resetReq in reset", {31'h0, resetReq}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, 32'h0);

    // exhaustive sweep: starting state x written flags
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 32; w++) begin
        st = s[4:0];
        doReset();
        if (st[4]) pulseSys();
        if (st[3] || st[2]) writeReg(ODD, fld({1'b0, st[3], st[2], 2'b00}));
        if (st[1] || st[0]) pulseBtn(st[1], st[0]);
        @(negedge clk);
        check("R10 built state", rdData, fld(st));
        writeReg(ODD, fld(w[4:0]) | 32'h05A5A5A5);
        expAfter = (st & ~(w[4:0] & 5'b10011)) | (w[4:0] & 5'b01100);
        check("R4 R5 R6 write result", rdData, fld(expAfter));
        check("R8 R9 request pulse", {31'h0, reqSeen}, {31'h0, (w[3] | w[2])});
        check("R8 request one cycle", {31'h0, reqAfter}, 32'h0);
        zeroCnt = !st[4] || st[3] || w[3];
        pulseSys();
        check("R2 R3 R8 R9 after sysRst", rdData, zeroCnt ? fld(5'b10000) : fld(expAfter));
        pulseSys();
        check("R3 second sysRst keeps", rdData, zeroCnt ? fld(5'b10000) : fld(expAfter));
      end
    end

    // R3 saturation: many resets never look like a first one
    doReset();
    pulseSys();
    writeReg(ODD, fld(5'b00100));
    for (int k = 0; k < 6; k++) pulseSys();
    @(negedge clk);
    check("R3 count saturates", rdData, fld(5'b10100));

    // R7 even word and foreign address
    writeReg(BASE, 32'hFFFFFFFF);
    check("R7 even write no request", {31'h0, reqSeen}, 32'h0);
    check("R7 odd word untouched", rdData, fld(5'b10100));
    regAddr = BASE; #1;
    check("R7 even reads zero", rdData, 32'h0);
    writeReg(16'hF02C, 32'hFFFFFFFF);
    check("R7 foreign write ignored", rdData, fld(5'b10100));
    check("R7 foreign no request", {31'h0, reqSeen}, 32'h0);
    regAddr = 16'hF02C; #1;
    check("R7 foreign reads zero", rdData, 32'h0);
    regAddr = ODD;

    // R10 set wins over same-cycle clear
    pulseBtn(1'b1, 1'b0);
    @(negedge clk); regAddr = ODD; wrData = fld(5'b00011); wrEn = 1'b1; btnPor = 1'b1;
    @(negedge clk); wrEn = 1'b0; btnPor = 1'b0;
    check("R10 button beats clear", rdData, fld(5'b10110));

    // R11 writes ignored during sysRst
    doReset();
    @(negedge clk); wrData = fld(5'b01100); wrEn = 1'b1; sysRst = 1'b1; btnXir = 1'b1;
    @(negedge clk); wrEn = 1'b0; sysRst = 1'b0; btnXir = 1'b0; reqSeen = resetReq;
    check("R11 first reset wins", rdData, fld(5'b10000));
    check("R11 no request", {31'h0, reqSeen}, 32'h0);
    @(negedge clk); wrData = fld(5'b10000); wrEn = 1'b1; sysRst = 1'b1;
    @(negedge clk); wrEn = 1'b0; sysRst = 1'b0;
    check("R11 clear ignored in sysRst", rdData, fld(5'b10000));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule